// File: doc/BRIEF.md
# ARGB to 16-colour cursor encoder

This block turns a 64x64 cursor image of 32-bit ARGB pixels into a 4-bit palettized cursor image and the palette register writes that go with it. The image arrives twice over a valid/ready pixel stream, in row-major order. The first pass checks every alpha byte. It also collects the distinct opaque colours, in the order in which they first appear. The second pass emits the encoded rows, 48 bytes each, on a byte stream.

When the first pass ends cleanly, the block issues one register write for each colour component of each palette entry. It encodes the second pass and then writes a final control value. The image is rejected, and `error` is raised, for any of these: a wrong declared size, a partially transparent pixel, or more than 16 distinct opaque colours.

The palette lookup compares the incoming colour against all entries in the same cycle. Each pass therefore takes one pixel per clock. Input is paused only while the palette is written and while a finished row is emitted.

Top module: `argb_cursor_enc`

## Requirements
- R1: A `start` pulse with `size_w` or `size_h` different from 64 puts the block in the error state (`error`=1, `done`=0). A start with 64x64 begins the first pass.
- R2: In the first pass, a pixel whose alpha byte (bits 31:24) is neither 0x00 nor 0xFF raises `error`.
- R3: A pixel with alpha 0x00 is transparent, and its RGB bits never enter the palette, whatever their value.
- R4: Opaque colours (alpha 0xFF, RGB in bits 23:0) are stored in order of first appearance. There may be up to 16 of them. A 17th distinct colour raises `error`, while exactly 16 colours are accepted.
- R5: Every output row is 48 bytes that start at zero. An opaque pixel in column c puts its 4-bit palette index into byte c/2: the low nibble when c is even, the high nibble when c is odd.
- R6: A transparent pixel in column c sets bit 7-(c mod 8) of byte 47-c/8, and its index nibble stays zero.
- R7: Palette entry i is written to register 0x08+4i when i is 0 to 2, and to 0x60+3i otherwise. The three writes go to consecutive registers and carry the colour's bits 7:0, then 15:8, then 23:16. The palette phase lasts 3n+1 cycles for n colours, and its last cycle makes no write.
- R8: No register write and no row byte appears before the first pass has completed without error. In the error state, `px_ready` stays high, the stream is swallowed and nothing is output until the next `start`.
- R9: During the first pass, `px_ready` stays high, so one pixel is accepted every cycle.
- R10: After the last row, the block makes one write of value 0x04 to register 0x19 and then holds `done` high until the next `start`.
- R11: After each complete row of the second pass, its 48 bytes are emitted on consecutive cycles, byte 0 first, while `px_ready` is low. Across the second pass, the input stalls for 3n+1+63*48 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new conversion and samples the declared size |
| size_w | input | 16 | Declared image width |
| size_h | input | 16 | Declared image height |
| px_valid | input | 1 | Pixel data valid |
| px_ready | output | 1 | Block accepts a pixel this cycle |
| px_data | input | 32 | ARGB pixel, alpha in bits 31:24 |
| ob_valid | output | 1 | Row byte valid |
| ob_data | output | 8 | Encoded row byte |
| reg_valid | output | 1 | Register write valid |
| reg_idx | output | 8 | Register index |
| reg_data | output | 8 | Register data |
| done | output | 1 | Conversion finished successfully |
| error | output | 1 | Conversion rejected |

## Verification
A fully transparent image has an empty palette. It shows that transparent bits land in the upper bytes and that the palette phase adds only its idle cycle. An image with exactly 16 colours, plus transparent pixels carrying non-zero RGB, exercises the low and high register bases, the full palette and both nibble positions. It also shows that transparent pixels never take a palette slot. A sparse three-colour image whose first-appearance order differs from the colour values separates first-appearance indexing from any sorted order. Error images carry a 17th colour at the very last pixel, a half-transparent pixel in mid-stream, or a wrong declared size. Each must leave both output streams silent, and a clean image that follows confirms the restart.

// File: rtl/argb_cursor_enc.sv
module argb_cursor_enc #(
  parameter logic [7:0] CTRL_IDX = 8'h19,
  parameter logic [7:0] CTRL_VAL = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] size_w,
  input  logic [15:0] size_h,
  input  logic        px_valid,
  output logic        px_ready,
  input  logic [31:0] px_data,
  output logic        ob_valid,
  output logic [7:0]  ob_data,
  output logic        reg_valid,
  output logic [7:0]  reg_idx,
  output logic [7:0]  reg_data,
  output logic        done,
  output logic        error
);
  localparam int SIDE = 64;
  localparam int ROWB = 48;
  localparam int NCOL = 16;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_PAL, S_ENC, S_EMIT, S_CTRL, S_DONE, S_ERR} st_t;
  st_t st;

  logic [11:0] cnt;
  logic [23:0] pal [NCOL];
  logic [4:0]  pal_n;
  logic [4:0]  ent;
  logic [1:0]  comp;
  logic [5:0]  bcnt;
  logic [7:0]  row    [ROWB];
  logic [7:0]  row_nx [ROWB];

  wire [7:0]  alpha  = px_data[31:24];
  wire [23:0] rgb    = px_data[23:0];
  wire        take   = px_valid && px_ready;
  wire        opaque = alpha == 8'hFF;
  wire        clear  = alpha == 8'h00;
  wire [5:0]  col    = cnt[5:0];
  wire [5:0]  tbyte  = 6'd47 - {3'b0, col[5:3]};

  logic       hit;
  logic [3:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = 4'd0;
    for (int i = NCOL - 1; i >= 0; i--)
      if (5'(i) < pal_n && pal[i] == rgb) begin
        hit = 1'b1;
        hit_idx = 4'(i);
      end
  end

  wire        new_col = opaque && !hit;
  wire        overflow = new_col && pal_n == 5'(NCOL);

  assign px_ready  = st == S_SCAN || st == S_ENC || st == S_ERR;
  assign ob_valid  = st == S_EMIT;
  assign ob_data   = row[bcnt];
  assign done      = st == S_DONE;
  assign error     = st == S_ERR;
  assign reg_valid = (st == S_PAL && ent != pal_n) || st == S_CTRL;

  wire [7:0]  ent8 = {4'b0, ent[3:0]};
  wire [7:0]  base = ent < 5'd3 ? 8'h08 + (ent8 << 2) : 8'h60 + ent8 * 8'd3;
  wire [23:0] cur  = pal[ent[3:0]];
  assign reg_idx  = st == S_CTRL ? CTRL_IDX : base + {6'b0, comp};
  assign reg_data = st == S_CTRL ? CTRL_VAL :
                    comp == 2'd0 ? cur[7:0] : comp == 2'd1 ? cur[15:8] : cur[23:16];

  always_comb
    for (int b = 0; b < ROWB; b++) begin
      row_nx[b] = col == 6'd0 ? 8'h00 : row[b];
      if (!clear && 6'(b) == col[5:1])
        row_nx[b] = row_nx[b] | (col[0] ? {hit_idx, 4'b0} : {4'b0, hit_idx});
      if (clear && 6'(b) == tbyte)
        row_nx[b] = row_nx[b] | (8'h80 >> col[2:0]);
    end

  always_ff @(posedge clk)
    if (st == S_ENC && take)
      for (int b = 0; b < ROWB; b++) row[b] <= row_nx[b];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0; pal_n <= '0; ent <= '0; comp <= '0; bcnt <= '0;
    end else if (start) begin
      cnt <= '0; pal_n <= '0; ent <= '0; comp <= '0; bcnt <= '0;
      st <= (size_w == 16'(SIDE) && size_h == 16'(SIDE)) ? S_SCAN : S_ERR;
    end else begin
      case (st)
        S_SCAN: if (take) begin
          if (!opaque && !clear) st <= S_ERR;
          else if (overflow) st <= S_ERR;
          else begin
            if (new_col) begin
              pal[pal_n[3:0]] <= rgb;
              pal_n <= pal_n + 5'd1;
            end
            cnt <= cnt + 12'd1;
            if (cnt == 12'hFFF) st <= S_PAL;
          end
        end
        S_PAL:
          if (ent == pal_n) st <= S_ENC;
          else if (comp == 2'd2) begin
            comp <= 2'd0;
            ent <= ent + 5'd1;
          end else comp <= comp + 2'd1;
        S_ENC: if (take) begin
          cnt <= cnt + 12'd1;
          if (col == 6'(SIDE - 1)) begin
            st <= S_EMIT;
            bcnt <= '0;
          end
        end
        S_EMIT: begin
          bcnt <= bcnt + 6'd1;
          if (bcnt == 6'(ROWB - 1)) st <= (cnt == 12'd0) ? S_CTRL : S_ENC;
        end
        S_CTRL: st <= S_DONE;
        default: ;
      endcase
    end
  end

  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R1
  AST_BAD_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SCAN && take && !opaque && !clear && !start |=> error); // R2
  AST_PAL_CAP: assert property (@(posedge clk) disable iff (!rst_n) pal_n <= 5'(NCOL)); // R4
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) error && !start |=> error); // R8
  AST_SILENT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !ob_valid && !reg_valid && px_ready); // R8
  AST_DONE_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(reg_valid && reg_idx == CTRL_IDX && reg_data == CTRL_VAL)); // R10
  AST_NO_READY_EMIT: assert property (@(posedge clk) disable iff (!rst_n) ob_valid |-> !px_ready); // R11
endmodule

// File: tb/tb_argb_cursor_enc.sv
module tb_argb_cursor_enc;
  logic clk = 0, rst_n = 0, start = 0, px_valid = 0;
  logic [15:0] size_w = 16'd64, size_h = 16'd64;
  logic [31:0] px_data = '0;
  logic px_ready, ob_valid, reg_valid, done, error;
  logic [7:0] ob_data, reg_idx, reg_data;

  always #5 clk = ~clk;

  argb_cursor_enc dut (.clk(clk), .rst_n(rst_n), .start(start), .size_w(size_w), .size_h(size_h),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data), .ob_valid(ob_valid),
    .ob_data(ob_data), .reg_valid(reg_valid), .reg_idx(reg_idx), .reg_data(reg_data),
    .done(done), .error(error));

  int checks = 0, errors = 0;
  logic [7:0] obuf [3072];
  logic [7:0] ri [64];
  logic [7:0] rd [64];
  int ob_n = 0, rw_n = 0;
  logic [23:0] epal [17];
  int en;
  logic [7:0] eb [3072];

  always @(negedge clk) begin
    if (ob_valid) begin if (ob_n < 3072) obuf[ob_n] = ob_data; ob_n++; end
    if (reg_valid) begin if (rw_n < 64) begin ri[rw_n] = reg_idx; rd[rw_n] = reg_data; end rw_n++; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] colk(input int k);
    return {8'hFF, 8'(k), 8'(k ^ 5), 8'(k * 7 + 1)};
  endfunction

  function automatic logic [31:0] pixel(input int id, input int r, input int c);
    case (id)
      0: return 32'h0;
      1: return c < 16 ? colk(c) : (c < 48 ? colk((r + c) % 16) : 32'h00123456);
      2: return ((r + c) % 3 == 0) ? 32'h0 : colk(((r >> 3) + c) % 3 + 5);
      3: return (r == 63 && c == 63) ? colk(16) : pixel(1, r, c);
      default: return (r == 1 && c == 36) ? 32'h80FFFFFF : pixel(2, r, c);
    endcase
  endfunction

  task automatic model(input int id);
    en = 0;
    for (int i = 0; i < 3072; i++) eb[i] = 8'h00;
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) begin
        logic [31:0] p;
        int k;
        p = pixel(id, r, c);
        k = -1;
        if (p[31:24] == 8'h00) eb[r * 48 + 47 - c / 8] |= 8'h80 >> (c % 8);
        else begin
          for (int j = 0; j < en; j++) if (epal[j] == p[23:0]) k = j;
          if (k < 0) begin epal[en] = p[23:0]; k = en; en++; end
          eb[r * 48 + c / 2] |= (c % 2) ? 8'(k << 4) : 8'(k);
        end
      end
  endtask

  task automatic do_start(input int w, input int h);
    @(negedge clk);
    start = 1; size_w = 16'(w); size_h = 16'(h);
    ob_n = 0; rw_n = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic stream(input int id, output int stalls, output int early);
    stalls = 0;
    early = 0;
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) begin
        if (c != 0 || r != 0) @(negedge clk);
        px_valid = 1;
        px_data = pixel(id, r, c);
        while (!px_ready) begin stalls++; @(negedge clk); end
        if (r == 63 && c == 63) early = ob_n + rw_n;
      end
    @(negedge clk);
    px_valid = 0;
  endtask

  task automatic run_ok(input int id, input string name);
    int s1, s2, e1, e2, t;
    model(id);
    do_start(64, 64);
    stream(id, s1, e1);
    chk(s1 == 0, "R9", {name, " first-pass stalls"}, s1, 0);
    chk(e1 == 0, "R8", {name, " outputs before first pass end"}, e1, 0);
    stream(id, s2, e2);
    chk(s2 == 3 * en + 1 + 63 * 48, "R11", {name, " second-pass stalls"}, s2, 3 * en + 1 + 63 * 48);
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    chk(done && !error, "R10", {name, " done"}, done, 1);
    chk(rw_n == 3 * en + 1, "R7", {name, " register write count"}, rw_n, 3 * en + 1);
    for (int i = 0; i < en && i < 16; i++)
      for (int k = 0; k < 3; k++) begin
        int ei, ed;
        ei = (i <= 2 ? 8 + 4 * i : 96 + 3 * i) + k;
        ed = int'(epal[i] >> (8 * k)) & 255;
        chk(ri[3 * i + k] == 8'(ei), "R7", {name, " palette index"}, ri[3 * i + k], ei);
        chk(rd[3 * i + k] == 8'(ed), i == 0 ? "R4" : "R7", {name, " palette data"}, rd[3 * i + k], ed);
      end
    if (rw_n >= 1 && rw_n <= 64) begin
      chk(ri[rw_n - 1] == 8'h19, "R10", {name, " control index"}, ri[rw_n - 1], 25);
      chk(rd[rw_n - 1] == 8'h04, "R10", {name, " control value"}, rd[rw_n - 1], 4);
    end
    chk(ob_n == 3072, "R11", {name, " row byte count"}, ob_n, 3072);
    for (int r = 0; r < 64; r++) begin
      int bad;
      bad = -1;
      for (int b = 47; b >= 0; b--) if (obuf[r * 48 + b] !== eb[r * 48 + b]) bad = b;
      if (bad < 0) chk(1, "R5", name, 0, 0);
      else chk(0, bad >= 40 ? "R6" : "R5", {name, " row byte"}, obuf[r * 48 + bad], eb[r * 48 + bad]);
    end
  endtask

  task automatic run_err(input int id, input string req, input string name);
    int s1, e1;
    do_start(64, 64);
    stream(id, s1, e1);
    repeat (3) @(negedge clk);
    chk(error && !done, req, {name, " error flag"}, error, 1);
    chk(ob_n + rw_n == 0, "R8", {name, " outputs after error"}, ob_n + rw_n, 0);
    chk(px_ready, "R8", {name, " stream swallowed"}, px_ready, 1);
  endtask

  task automatic run_size(input int w, input int h);
    do_start(w, h);
    repeat (2) @(negedge clk);
    chk(error && !done, "R1", "size error", error, 1);
    chk(ob_n + rw_n == 0, "R8", "size error outputs", ob_n + rw_n, 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !error && !px_ready && !ob_valid && !reg_valid, "R8", "reset state",
        {done, error, px_ready, ob_valid, reg_valid}, 0);
    run_ok(0, "all transparent R6");
    run_ok(1, "sixteen colours R3 R4");
    run_err(3, "R4", "seventeenth colour");
    run_ok(2, "restart three colours R5");
    run_err(4, "R2", "partial alpha");
    run_size(32, 64);
    run_size(64, 65);
    run_ok(2, "after size error R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule